// File: doc/BRIEF.md
# PCI Power-Management Wake Event Controller

This block keeps the device-side PCI power-management state of a chip and drives the active-low, open-drain-style wake request line toward the host. A configuration write port carries a control/status word. That word holds the power-state field, a wake-enable bit and a write-one-to-clear wake-status bit. A separate software register port carries a one-shot wake request. The block only reports requests and state changes. Other logic on the chip acts on the state it exports. Power gating, clock stopping and any host-side control sit outside it.

The live power states are D0, D1 and D3hot. The D2 code is rejected. D3cold is signalled by the `cold_i` input, which marks supply removal. No wake event can be raised while it is high. Leaving D3cold goes through the active-low reset, which returns every register to its initial value.

Top module: `pcipm_wake_ctrl`

## Requirements
- R1: While `rst_ni` is low and after it is released, `pstate_o` is D0 (2'b00), enable and status are 0, `cfg_rdata_o` is all zero and `pme_n_o` is 1.
- R2: A configuration write whose power-state field (`cfg_wdata_i[1:0]`, encoding 00 = D0, 01 = D1, 11 = D3hot) is not 10 loads that state into `pstate_o` at the next clock edge.
- R3: A configuration write carrying the state code 10 (D2) leaves `pstate_o` unchanged.
- R4: A software write (`sw_we_i`) with `sw_req_i` = 1 while `cold_i` is low sets the wake-status flag (`pme_st_o`, also `cfg_rdata_o[15]`) at the next edge. A software write with `sw_req_i` = 0 does not set it.
- R5: `pme_n_o` is 0 exactly when both the enable bit (`cfg_wdata_i[8]`, read back on `cfg_rdata_o[8]`) and the status flag are 1. Otherwise it is 1.
- R6: A configuration write with bit 15 set clears the status flag and releases `pme_n_o`. A write with bit 15 at 0 leaves the status flag as it was.
- R7: A wake request made while `cold_i` is high is ignored, and the status flag stays 0.
- R8: The request is a single-cycle pulse that is not stored. Once the status flag is cleared, it stays 0 until a new request arrives.
- R9: When a request and a status clear land in the same cycle, the request wins and the status flag ends at 1.
- R10: Every configuration write loads the enable bit from bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, also the exit path from D3cold |
| cold_i | input | 1 | High while the device is in D3cold |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | CFG_W | Configuration write word: [1:0] state, [8] enable, [15] status clear |
| sw_we_i | input | 1 | Software register write strobe |
| sw_req_i | input | 1 | Wake request bit of the software write |
| pstate_o | output | 2 | Current power state |
| cfg_rdata_o | output | CFG_W | Readback of state, enable and status |
| pme_st_o | output | 1 | Wake status flag |
| pme_n_o | output | 1 | Active-low wake request line |

## Verification
State writes walk through every code, including 10 issued from two different prior states. This separates a true hold from a fall-back to a fixed value. Wake requests are tried with enable on and off, with `cold_i` high, with the request bit at 0, and in the same cycle as a clear. Together these separate the set path, the output gating, the cold filter and the set-over-clear priority. A clear followed by idle cycles shows that the request was not latched. A reset taken from D3hot with the line asserted shows the full return to the initial state.

// File: rtl/pcipm_pkg.sv
package pcipm_pkg;
  typedef enum logic [1:0] {
    PS_D0    = 2'b00,
    PS_D1    = 2'b01,
    PS_D2    = 2'b10,
    PS_D3HOT = 2'b11
  } pstate_e;

  function automatic logic is_live(pstate_e s);
    return (s != PS_D2);
  endfunction
endpackage

// File: rtl/pcipm_state_reg.sv
module pcipm_state_reg
  import pcipm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    we_i,
  input  logic [1:0] field_i,
  output pstate_e state_o
);
  pstate_e state_q;
  pstate_e field_s;

  assign field_s = pstate_e'(field_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        state_q <= PS_D0;
    else if (we_i && is_live(field_s))  state_q <= field_s;
  end

  assign state_o = state_q;
endmodule

// File: rtl/pcipm_pme_ctrl.sv
module pcipm_pme_ctrl
  import pcipm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  pstate_e state_i,
  input  logic    cold_i,
  input  logic    req_we_i,
  input  logic    req_i,
  input  logic    cfg_we_i,
  input  logic    en_d_i,
  input  logic    clr_d_i,
  output logic    en_o,
  output logic    st_o
);
  logic en_q, st_q;
  logic set_s, clr_s;

  // request only from a live, powered state
  assign set_s = req_we_i & req_i & ~cold_i & is_live(state_i);
  assign clr_s = cfg_we_i & clr_d_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      st_q <= 1'b0;
    end else begin
      if (cfg_we_i) en_q <= en_d_i;
      if (set_s)      st_q <= 1'b1;  // set beats clear
      else if (clr_s) st_q <= 1'b0;
    end
  end

  assign en_o = en_q;
  assign st_o = st_q;
endmodule

// File: rtl/pcipm_pme_drv.sv
module pcipm_pme_drv #(
  parameter bit OUT_REG = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic st_i,
  output logic pme_n_o
);
  logic drive_s;
  assign drive_s = en_i & st_i;

  generate
    if (OUT_REG) begin : g_reg
      logic pme_n_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pme_n_q <= 1'b1;
        else         pme_n_q <= ~drive_s;
      end
      assign pme_n_o = pme_n_q;
    end else begin : g_comb
      assign pme_n_o = ~drive_s;
    end
  endgenerate
endmodule

// File: rtl/pcipm_wake_ctrl.sv
module pcipm_wake_ctrl
  import pcipm_pkg::*;
#(
  parameter int unsigned CFG_W   = 16,
  parameter int unsigned PS_LSB  = 0,
  parameter int unsigned EN_BIT  = 8,
  parameter int unsigned ST_BIT  = 15,
  parameter bit          OUT_REG = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cold_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             sw_we_i,
  input  logic             sw_req_i,
  output logic [1:0]       pstate_o,
  output logic [CFG_W-1:0] cfg_rdata_o,
  output logic             pme_st_o,
  output logic             pme_n_o
);
  localparam int unsigned PS_W = 2;

  pstate_e state_s;
  logic    en_s, st_s;

  pcipm_state_reg u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .field_i (cfg_wdata_i[PS_LSB +: PS_W]),
    .state_o (state_s)
  );

  pcipm_pme_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_i  (state_s),
    .cold_i   (cold_i),
    .req_we_i (sw_we_i),
    .req_i    (sw_req_i),
    .cfg_we_i (cfg_we_i),
    .en_d_i   (cfg_wdata_i[EN_BIT]),
    .clr_d_i  (cfg_wdata_i[ST_BIT]),
    .en_o     (en_s),
    .st_o     (st_s)
  );

  pcipm_pme_drv #(.OUT_REG(OUT_REG)) u_drv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_s),
    .st_i    (st_s),
    .pme_n_o (pme_n_o)
  );

  always_comb begin
    cfg_rdata_o                   = '0;
    cfg_rdata_o[PS_LSB +: PS_W]   = state_s;
    cfg_rdata_o[EN_BIT]           = en_s;
    cfg_rdata_o[ST_BIT]           = st_s;
  end

  assign pstate_o = state_s;
  assign pme_st_o = st_s;
endmodule

// File: rtl/pcipm_wake_ctrl_chk.sv
module pcipm_wake_ctrl_chk #(
  parameter int unsigned CFG_W   = 16,
  parameter int unsigned PS_LSB  = 0,
  parameter int unsigned EN_BIT  = 8,
  parameter int unsigned ST_BIT  = 15,
  parameter bit          OUT_REG = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cold_i,
  input logic             cfg_we_i,
  input logic [CFG_W-1:0] cfg_wdata_i,
  input logic             sw_we_i,
  input logic             sw_req_i,
  input logic [1:0]       pstate_o,
  input logic [CFG_W-1:0] cfg_rdata_o,
  input logic             pme_st_o,
  input logic             pme_n_o
);
  logic set_req;
  assign set_req = sw_we_i & sw_req_i & ~cold_i;

  p_state_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_wdata_i[PS_LSB +: 2] != 2'b10)
      |=> pstate_o == $past(cfg_wdata_i[PS_LSB +: 2]));

  p_d2_reject_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_wdata_i[PS_LSB +: 2] == 2'b10) |=> $stable(pstate_o));

  p_req_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_req |=> pme_st_o);

  generate
    if (!OUT_REG) begin : g_out
      p_line_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pme_st_o && cfg_rdata_o[EN_BIT]) |-> !pme_n_o);
      p_line_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pme_st_o |-> pme_n_o);
    end
  endgenerate

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_wdata_i[ST_BIT] && !set_req) |=> !pme_st_o);

  p_cold_ignore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cold_i && !pme_st_o) |=> !pme_st_o);

  p_no_spont_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pme_st_o && !set_req) |=> !pme_st_o);

  p_en_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_rdata_o[EN_BIT] == $past(cfg_wdata_i[EN_BIT]));
endmodule

bind pcipm_wake_ctrl pcipm_wake_ctrl_chk #(
  .CFG_W(CFG_W), .PS_LSB(PS_LSB), .EN_BIT(EN_BIT), .ST_BIT(ST_BIT), .OUT_REG(OUT_REG)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cold_i(cold_i), .cfg_we_i(cfg_we_i),
  .cfg_wdata_i(cfg_wdata_i), .sw_we_i(sw_we_i), .sw_req_i(sw_req_i),
  .pstate_o(pstate_o), .cfg_rdata_o(cfg_rdata_o), .pme_st_o(pme_st_o),
  .pme_n_o(pme_n_o)
);

// File: tb/pcipm_wake_ctrl_tb_top.sv
module pcipm_wake_ctrl_tb_top;
  localparam int CFG_W = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cold_i = 1'b0;
  logic             cfg_we_i = 1'b0;
  logic [CFG_W-1:0] cfg_wdata_i = '0;
  logic             sw_we_i = 1'b0;
  logic             sw_req_i = 1'b0;
  logic [1:0]       pstate_o;
  logic [CFG_W-1:0] cfg_rdata_o;
  logic             pme_st_o;
  logic             pme_n_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  pcipm_wake_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cold_i(cold_i), .cfg_we_i(cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i), .sw_we_i(sw_we_i), .sw_req_i(sw_req_i),
    .pstate_o(pstate_o), .cfg_rdata_o(cfg_rdata_o), .pme_st_o(pme_st_o),
    .pme_n_o(pme_n_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] w(logic [1:0] ps, logic en, logic clr);
    logic [15:0] d = '0;
    d[1:0] = ps; d[8] = en; d[15] = clr;
    return d;
  endfunction

  // one write cycle; outputs sampled at the following negedge
  task automatic cfg_wr(logic [15:0] d);
    @(negedge clk_i); cfg_we_i = 1'b1; cfg_wdata_i = d;
    @(negedge clk_i); cfg_we_i = 1'b0; cfg_wdata_i = '0;
  endtask

  task automatic sw_wr(logic req);
    @(negedge clk_i); sw_we_i = 1'b1; sw_req_i = req;
    @(negedge clk_i); sw_we_i = 1'b0; sw_req_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0; #1;
    chk("R1 state in reset", pstate_o, 0);
    chk("R1 line in reset", pme_n_o, 1);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 rdata after reset", cfg_rdata_o, 0);
    chk("R1 status after reset", pme_st_o, 0);
    chk("R1 line after reset", pme_n_o, 1);
  endtask

  task automatic t_states();
    cfg_wr(w(2'b01, 0, 0)); chk("R2 D1", pstate_o, 2'b01);
    cfg_wr(w(2'b10, 0, 0)); chk("R3 D2 from D1", pstate_o, 2'b01);
    cfg_wr(w(2'b11, 0, 0)); chk("R2 D3hot", pstate_o, 2'b11);
    cfg_wr(w(2'b10, 0, 0)); chk("R3 D2 from D3hot", pstate_o, 2'b11);
    cfg_wr(w(2'b00, 0, 0)); chk("R2 D0", pstate_o, 2'b00);
  endtask

  task automatic t_pme_basic();
    cfg_wr(w(2'b01, 1, 0));
    chk("R10 enable set", cfg_rdata_o[8], 1);
    chk("R5 no status line high", pme_n_o, 1);
    sw_wr(1'b0);
    chk("R4 req bit 0 no set", pme_st_o, 0);
    sw_wr(1'b1);
    chk("R4 status set", pme_st_o, 1);
    chk("R4 status readback", cfg_rdata_o[15], 1);
    chk("R5 line low", pme_n_o, 0);
    cfg_wr(w(2'b01, 1, 0));
    chk("R6 zero write keeps status", pme_st_o, 1);
    cfg_wr(w(2'b01, 1, 1));
    chk("R6 W1C clears", pme_st_o, 0);
    chk("R6 line released", pme_n_o, 1);
    repeat (5) @(negedge clk_i);
    chk("R8 no re-set after clear", pme_st_o, 0);
  endtask

  task automatic t_enable_gate();
    cfg_wr(w(2'b11, 0, 1));
    chk("R10 enable cleared", cfg_rdata_o[8], 0);
    sw_wr(1'b1);
    chk("R4 set in D3hot", pme_st_o, 1);
    chk("R5 disabled line high", pme_n_o, 1);
    cfg_wr(w(2'b11, 1, 0));
    chk("R5 enabled line low", pme_n_o, 0);
  endtask

  task automatic t_collide();
    cfg_wr(w(2'b00, 1, 1));
    chk("R9 precondition", pme_st_o, 0);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = w(2'b00, 1, 1);
    sw_we_i = 1'b1; sw_req_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0; cfg_wdata_i = '0; sw_we_i = 1'b0; sw_req_i = 1'b0;
    chk("R9 set wins", pme_st_o, 1);
    chk("R9 line low", pme_n_o, 0);
  endtask

  task automatic t_cold();
    cfg_wr(w(2'b11, 1, 1));
    cold_i = 1'b1;
    sw_wr(1'b1);
    chk("R7 cold request ignored", pme_st_o, 0);
    chk("R7 cold line high", pme_n_o, 1);
    do_reset();
    cold_i = 1'b0;
  endtask

  task automatic t_reset_mid();
    cfg_wr(w(2'b11, 1, 0));
    sw_wr(1'b1);
    chk("R1 precondition line low", pme_n_o, 0);
    do_reset();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 line in reset", pme_n_o, 1);
    chk("R1 rdata in reset", cfg_rdata_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 state after reset", pstate_o, 0);
    t_states();
    t_pme_basic();
    t_enable_gate();
    t_collide();
    t_cold();
    t_reset_mid();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule